// File: doc/BRIEF.md
# Dual-Channel Input Capture Unit

This block watches two external capture pins, A and B, and records when each one changes. It shares a free-running 16-bit timer count with the rest of the timer. When a pin shows the edge that software selected for it, the unit copies the present count into that pin's own capture register. Each pin is handled independently. Each capture also sets a per-channel flag, and that flag can raise an interrupt when it is enabled.

Software uses a byte-wide register port to configure the unit and to read the results. A 16-bit capture is read in two accesses: the low byte first, then the high byte. Once the low byte of a channel has been read, new events on that pin are ignored until the high byte of the same channel has been read. This keeps the two halves from coming from different captures.

The pins are asynchronous. Each pin passes through a two-stage synchronizer before its edge is detected. A pin level that is first sampled at clock edge k therefore produces its capture at edge k+2, and the capture takes the timer count present at that edge.

Top module: `dual_capture`

## Requirements
- R1: Each pin has its own 2-bit edge select: bits [1:0] of register 0 for A and bits [3:2] for B. Within a select, the low bit enables capture on a rising edge and the high bit enables capture on a falling edge. 01 selects rising, 10 falling, 11 both, and 00 disables capture for that pin.
- R2: A pin level first sampled at clock edge k is seen as an edge at clock edge k+2. When that edge qualifies, it loads that channel's 16-bit capture register with the `timer_val` present at edge k+2.
- R3: Channel A's edges affect only capture register A, read at address 4 (low byte) and 5 (high byte). Channel B's edges affect only capture register B, read at address 6 (low byte) and 7 (high byte).
- R4: A read of a channel's low byte makes that channel ignore edges, with neither capture nor flag. This starts with an edge in the same cycle as the read and lasts until a read of that channel's high byte. An edge in the same cycle as the high-byte read is also ignored.
- R5: A read of a high byte with no pending low-byte read returns the stored high byte and leaves the channel unlocked.
- R6: Writes to addresses 2 through 7 change no register.
- R7: A capture sets the channel's flag in register 2 (bit 0 for A, bit 1 for B). A read of register 2 clears both flags after returning them. A capture in the same cycle as that read leaves its flag set.
- R8: `irq` is high exactly when some channel has both its flag and its enable set. The enables are in register 1: bit 0 for A and bit 1 for B.
- R9: After reset, all registers read 0: edge selects, enables, flags and captures. Both channels are unlocked and `irq` is low.
- R10: Registers 0 and 1 read back the values last written to them, with unused bits read as 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Shared free-running timer count |
| cap_a_pin | input | 1 | Capture pin A (asynchronous) |
| cap_b_pin | input | 1 | Capture pin B (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; side effects apply at the clock edge |
| addr | input | 3 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Each pin is driven with isolated single pulses, with back-to-back toggles and with steady levels, under each of the four edge selects. Rising-only and falling-only captures store different timer counts, which shows that the edge polarity is decoded and not just a change of level. The two pins are moved both alone and together, so that a capture leaking across channels would show up as a mismatch.

Read sequences are also mixed with pin activity:
- a low-byte read followed by edges and then a high-byte read, which shows whether the lock holds;
- a high-byte read without a low-byte read, which shows that no false lock is set;
- writes to read-only addresses;
- flag reads that coincide with captures.

// File: rtl/dual_capture.sv
module dual_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*DW-1:0] timer_val,
  input  logic          cap_a_pin,
  input  logic          cap_b_pin,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int TW = 2 * DW;

  logic [1:0] pin, sy1, sy2, pv, lock, flag, ien, hit, fire, rd_lo, rd_hi;
  logic [3:0] esel;
  logic [1:0][TW-1:0] cap;
  logic rd_flag;
  wire unused_wdata = ^wdata;

  assign pin     = {cap_b_pin, cap_a_pin};
  assign rd_flag = rd_en && addr == 3'd2;
  assign irq     = |(flag & ien);

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      rd_lo[c] = rd_en && addr == 3'(4 + 2 * c);
      rd_hi[c] = rd_en && addr == 3'(5 + 2 * c);
      hit[c]   = (esel[2*c] & sy2[c] & ~pv[c]) | (esel[2*c+1] & ~sy2[c] & pv[c]);
      fire[c]  = hit[c] & ~lock[c] & ~rd_lo[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      pv  <= '0;
    end else begin
      sy1 <= pin;
      sy2 <= sy1;
      pv  <= sy2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esel <= '0;
      ien  <= '0;
    end else if (wr_en) begin
      if (addr == 3'd0) esel <= wdata[3:0];
      if (addr == 3'd1) ien  <= wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap  <= '0;
      flag <= '0;
      lock <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (fire[c]) cap[c] <= timer_val;
        if (fire[c]) flag[c] <= 1'b1;
        else if (rd_flag) flag[c] <= 1'b0;
        if (rd_lo[c]) lock[c] <= 1'b1;
        else if (rd_hi[c]) lock[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = DW'(esel);
      3'd1:    rdata = DW'(ien);
      3'd2:    rdata = DW'(flag);
      3'd4:    rdata = cap[0][DW-1:0];
      3'd5:    rdata = cap[0][TW-1:DW];
      3'd6:    rdata = cap[1][DW-1:0];
      3'd7:    rdata = cap[1][TW-1:DW];
      default: rdata = '0;
    endcase
  end

  // R4
  lock_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock[0] |=> $stable(cap[0]));
  // R4
  lock_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock[1] |=> $stable(cap[1]));
  // R1
  no_sel_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esel[1:0] == 2'b00 |=> $stable(cap[0]));
  // R1
  no_sel_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esel[3:2] == 2'b00 |=> $stable(cap[1]));
  // R7
  flag_on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap[0] != $past(cap[0]) |-> flag[0]);
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ien == 2'b00 |-> !irq);
endmodule

// File: tb/test_dual_capture.sv
module test_dual_capture;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [15:0] timer_val = 16'h1234;
  logic cap_a_pin = 0, cap_b_pin = 0, wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  dual_capture i_dual_capture (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) timer_val <= timer_val + 16'd3;

  int m_sel, m_ien, m_flag;
  int m_cap[2];
  bit m_lock[2];
  bit h[2][4];

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_sel;
      1: return m_ien;
      2: return m_flag;
      4: return m_cap[0] & 255;
      5: return m_cap[0] >> 8;
      6: return m_cap[1] & 255;
      7: return m_cap[1] >> 8;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_ien = 0; m_flag = 0;
      for (int c = 0; c < 2; c++) begin
        m_cap[c] = 0; m_lock[c] = 0;
        for (int k = 0; k < 4; k++) h[c][k] = 0;
      end
    end else begin
      bit fire[2];
      for (int c = 0; c < 2; c++) begin
        bit rise, fall, lo, hi;
        for (int k = 3; k > 0; k--) h[c][k] = h[c][k-1];
        h[c][0] = (c == 0) ? cap_a_pin : cap_b_pin;
        rise = h[c][2] && !h[c][3];
        fall = !h[c][2] && h[c][3];
        lo = rd_en && addr == 4 + 2*c;
        hi = rd_en && addr == 5 + 2*c;
        fire[c] = ((rise && m_sel[2*c]) || (fall && m_sel[2*c+1])) && !m_lock[c] && !lo;
        if (fire[c]) m_cap[c] = timer_val;
        if (lo) m_lock[c] = 1; else if (hi) m_lock[c] = 0;
      end
      if (rd_en && addr == 2) m_flag = 0;
      for (int c = 0; c < 2; c++) if (fire[c]) m_flag = m_flag | (1 << c);
      if (wr_en && addr == 0) m_sel = wdata[3:0];
      if (wr_en && addr == 1) m_ien = wdata[1:0];
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    #1;
    checks++;
    if (irq !== ((m_flag & m_ien) != 0)) begin
      fails++;
      $display("FAIL R8 irq actual %0b expected %0b", irq, (m_flag & m_ien) != 0);
    end
  end

  task automatic rd(input int a, input string req);
    @(negedge clk); addr = 3'(a); rd_en = 1; #2;
    checks++;
    if (rdata !== 8'(exp_rd(a))) begin
      fails++;
      $display("FAIL %s read addr %0d actual %02h expected %02h", req, a, rdata, exp_rd(a));
    end
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); addr = 3'(a); wdata = 8'(d); wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic pins(input bit a, input bit b);
    @(negedge clk); cap_a_pin = a; cap_b_pin = b;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic rd_all(input string req);
    for (int a = 0; a < 8; a++) rd(a, req);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3); #1 rst_n = 1;
    rd_all("R9");
    wr(0, 8'hF9); wr(1, 8'hFE);
    rd(0, "R10"); rd(1, "R10"); rd(3, "R10");
    wr(1, 0);
    pins(1, 0); idle(4); pins(0, 0); idle(4);
    rd(4, "R2"); rd(5, "R2"); rd(6, "R3"); rd(7, "R3"); rd(2, "R7");
    pins(0, 1); idle(4); pins(0, 0); idle(4);
    rd(6, "R1"); rd(7, "R1"); rd(4, "R3"); rd(5, "R3");
    wr(1, 3); idle(2); rd(2, "R7"); idle(2);
    wr(0, 8'h0F);
    for (int i = 0; i < 6; i++) begin pins(i[0], !i[0]); idle(1); end
    pins(0, 0); idle(4);
    rd_all("R1"); rd(2, "R7");
    wr(0, 8'h03);
    rd(4, "R4");
    pins(1, 0); idle(4); pins(0, 0); idle(4);
    rd(4, "R4"); rd(5, "R4"); rd(2, "R4");
    pins(1, 0); idle(4); pins(0, 0); idle(4);
    rd(4, "R4"); rd(5, "R4");
    rd(5, "R5");
    pins(1, 0); idle(4); pins(0, 0); idle(4);
    rd(4, "R5"); rd(5, "R5");
    for (int a = 2; a < 8; a++) wr(a, 8'hA5);
    rd_all("R6");
    wr(0, 8'h00);
    pins(1, 1); idle(4); pins(0, 0); idle(4);
    rd_all("R1");
    wr(0, 8'h0F);
    for (int i = 0; i < 40; i++) begin
      pins((i * 7) % 3 == 0, (i * 5) % 4 < 2);
      if (i % 5 == 0) rd(4 + (i % 4), "R4");
      if (i % 7 == 0) rd(2, "R7");
    end
    idle(4); rd_all("R3");
    rst_n = 0; idle(2); #1 rst_n = 1;
    rd_all("R9");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule